// File: doc/BRIEF.md
# Serial Shift Port with Daisy-Chain Output

This block is the front end of a peripheral that is controlled over three wires: a serial clock, an active-low chip-select and a data line. All three pins are brought into the system-clock domain through two-flop synchronisers, and their edges are found there. The system clock must be fast enough to oversample the serial clock; a serial clock of 10 MHz needs a system clock of at least about 60 MHz.

While chip-select is low, each rising serial-clock edge shifts the data bit into a 16-bit register, most-significant bit first. The last stage of that register drives a serial output, so several ports can be chained or the previous word can be read back. A mode input selects the serial-clock edge that updates the output.

When chip-select returns high, the block passes the captured word to a command decoder. It also passes the number of bits received and a flag that says whether the frame held exactly one full word. A single-cycle strobe marks the hand-off.

Top module: `ser_shift_port`

## Requirements
- R1: Bits enter the 16-bit shift register at its least-significant end. The first bit of a 16-bit frame therefore ends up in bit 15 of `frame_word`.
- R2: A bit is taken only on a rising serial-clock edge while chip-select is low. While chip-select is high, serial-clock and data activity leave the shift register unchanged, and the next frame reads back the same contents.
- R3: A rising edge of chip-select produces a `frame_strobe` pulse that lasts exactly one system cycle. In that cycle, `frame_word`, `frame_bits` and `frame_valid` carry the new frame. These outputs then hold until the next chip-select rising edge.
- R4: With `lag_mode` = 0, `dout` changes only on falling serial-clock edges while chip-select is low, and takes the register's bit 15 at that moment. The first bit of a frame appears on `dout` at the falling edge that follows the 16th rising edge.
- R5: With `lag_mode` = 1, `dout` changes only on rising serial-clock edges while chip-select is low. It takes the bit 15 value the register held just before that edge's shift, so the first bit of a frame appears at the 17th rising edge.
- R6: A word sent as two 8-bit bursts, with chip-select held low through the pause between them, gives the same frame as one 16-bit burst.
- R7: The bit count is cleared when chip-select falls, counts rising edges, and saturates at 17. `frame_bits` reports the count, and `frame_valid` is 1 only when the count is exactly 16.
- R8: A synchronous reset clears the shift register, the count, `dout`, `frame_word`, `frame_bits`, `frame_valid` and `frame_strobe` to zero.
- R9: A pin change takes effect at the third system-clock rising edge after it: two synchroniser stages, then the edge-detect stage. For example, `frame_strobe` goes high on the third system edge after chip-select rises.
- R10: While chip-select is high, `dout` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial clock pin (asynchronous) |
| csn_in | input | 1 | Active-low chip-select pin (asynchronous) |
| din_in | input | 1 | Serial data pin (asynchronous) |
| lag_mode | input | 1 | 0: `dout` updates on falling edges; 1: `dout` updates on rising edges |
| dout | output | 1 | Serial output from bit 15 of the shift register |
| frame_word | output | 16 | Word captured at the last chip-select rising edge |
| frame_bits | output | 5 | Number of bits received in that frame, saturating at 17 |
| frame_strobe | output | 1 | One-cycle pulse when a frame is handed over |
| frame_valid | output | 1 | The frame held exactly 16 bits |

## Verification
The assertions check on every cycle the properties that hold locally:

- the register and output do not move while chip-select is high;
- `dout` changes only on the edge its mode selects;
- the count stays within its bound;
- the strobe lasts one cycle;
- the frame outputs change only at a hand-off;
- reset clears the state.

The bench's scenarios show the properties that need a whole transfer:

- the order of bits in a frame;
- readback of the previous word through `dout` in both modes;
- split transfers;
- short and over-long frames;
- the three-cycle latency from the pins.

A behavioural model compares every output on every cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    parameter int unsigned WORD_W      = 16;
    parameter int unsigned SYNC_STAGES = 2;

    localparam int unsigned CNT_MAX = WORD_W + 1;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        LAUNCH_FALL = 1'b0,
        LAUNCH_RISE = 1'b1
    } launch_e;

    // Pin bundle; reset value is clock low, deselected, data low.
    typedef struct packed {
        logic sclk;
        logic csn;
        logic din;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, csn: 1'b1, din: 1'b0};

    // Events found in the system-clock domain.
    typedef struct packed {
        logic take;      // rising serial edge while selected
        logic fall_sel;  // falling serial edge while selected
        logic start;     // chip-select falling
        logic finish;    // chip-select rising
        logic idle;      // deselected
        logic bit_in;    // synchronised data
    } evt_t;

    typedef struct packed {
        word_t word;
        cnt_t  bits;
        logic  full;
    } frame_t;

    function automatic cnt_t cnt_step(cnt_t c);
        return (c >= cnt_t'(CNT_MAX)) ? c : c + cnt_t'(1);
    endfunction

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= INIT;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ssp_edge.sv
module ssp_edge
    import ssp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins,
    output evt_t  ev
);

    pins_t prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= PINS_IDLE;
        else     prev <= pins;
    end

    always_comb begin
        ev.idle     = pins.csn;
        ev.take     = pins.sclk & ~prev.sclk & ~pins.csn;
        ev.fall_sel = ~pins.sclk & prev.sclk & ~pins.csn;
        ev.start    = ~pins.csn & prev.csn;
        ev.finish   = pins.csn & ~prev.csn;
        ev.bit_in   = pins.din;
    end

    a_r2_no_take_when_idle: assert property (@(posedge clk) disable iff (rst)
        ev.idle |-> !(ev.take || ev.fall_sel));

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
    import ssp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  evt_t    ev,
    input  launch_e mode,
    output word_t   shreg,
    output cnt_t    cnt,
    output logic    dout
);

    logic launch;

    always_comb begin
        launch = (mode == LAUNCH_RISE) ? ev.take : ev.fall_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
            dout  <= 1'b0;
        end else begin
            if (ev.take)       shreg <= {shreg[WORD_W-2:0], ev.bit_in};
            if (ev.start)      cnt   <= '0;
            else if (ev.take)  cnt   <= cnt_step(cnt);
            if (launch)        dout  <= shreg[WORD_W-1];
        end
    end

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (shreg == '0 && cnt == '0 && dout == 1'b0));

    a_r2_reg_frozen_idle: assert property (@(posedge clk) disable iff (rst)
        ev.idle |=> $stable(shreg));

    a_r10_dout_held_idle: assert property (@(posedge clk) disable iff (rst)
        ev.idle |=> $stable(dout));

    a_r4_fall_mode_only: assert property (@(posedge clk) disable iff (rst)
        (mode == LAUNCH_FALL && !ev.fall_sel) |=> $stable(dout));

    a_r5_rise_mode_only: assert property (@(posedge clk) disable iff (rst)
        (mode == LAUNCH_RISE && !ev.take) |=> $stable(dout));

    a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= cnt_t'(CNT_MAX));

endmodule

// File: rtl/ssp_capture.sv
module ssp_capture
    import ssp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  evt_t   ev,
    input  word_t  shreg,
    input  cnt_t   cnt,
    output frame_t frame,
    output logic   strobe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame  <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= ev.finish;
            if (ev.finish) begin
                frame.word <= shreg;
                frame.bits <= cnt;
                frame.full <= (cnt == cnt_t'(WORD_W));
            end
        end
    end

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    a_r3_frame_holds: assert property (@(posedge clk) disable iff (rst)
        !ev.finish |=> $stable(frame));

    a_r7_valid_exact: assert property (@(posedge clk) disable iff (rst)
        frame.full |-> (frame.bits == cnt_t'(WORD_W)));

endmodule

// File: rtl/ser_shift_port.sv
module ser_shift_port
    import ssp_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              csn_in,
    input  logic              din_in,
    input  logic              lag_mode,
    output logic              dout,
    output logic [WORD_W-1:0] frame_word,
    output logic [CNT_W-1:0]  frame_bits,
    output logic              frame_strobe,
    output logic              frame_valid
);

    pins_t  raw_pins;
    pins_t  syn_pins;
    evt_t   ev;
    word_t  shreg;
    cnt_t   cnt;
    frame_t frame;

    assign raw_pins = '{sclk: sclk_in, csn: csn_in, din: din_in};

    ssp_sync #(.W($bits(pins_t)), .STAGES(SYNC_DEPTH), .INIT(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (syn_pins)
    );

    ssp_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .pins (syn_pins),
        .ev   (ev)
    );

    ssp_shifter u_shift (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .mode  (launch_e'(lag_mode)),
        .shreg (shreg),
        .cnt   (cnt),
        .dout  (dout)
    );

    ssp_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .shreg  (shreg),
        .cnt    (cnt),
        .frame  (frame),
        .strobe (frame_strobe)
    );

    assign frame_word  = frame.word;
    assign frame_bits  = frame.bits;
    assign frame_valid = frame.full;

endmodule

// File: tb/test_ser_shift_port.sv
module test_ser_shift_port;

    localparam int H = 4;  // serial half period in system cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, csn = 1'b1, din = 1'b0, mode = 1'b0;
    logic dout, strobe, valid;
    logic [15:0] word;
    logic [4:0]  bits;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    ser_shift_port i_ser_shift_port (
        .clk(clk), .rst(rst), .sclk_in(sclk), .csn_in(csn), .din_in(din),
        .lag_mode(mode), .dout(dout), .frame_word(word), .frame_bits(bits),
        .frame_strobe(strobe), .frame_valid(valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural reference: pin history sampled each edge, queue for the register
    logic [3:0] hs = 4'b0000, hc = 4'b1111, hd = 4'b0000;
    bit   sr_q[$];
    int   m_cnt = 0;
    bit   m_dout = 0, m_strobe = 0, m_valid = 0;
    int   m_bits = 0;
    logic [15:0] m_word = '0;

    function automatic logic [15:0] q_word();
        logic [15:0] w;
        for (int i = 0; i < 16; i++) w[15-i] = sr_q[i];
        return w;
    endfunction

    always @(posedge clk) begin
        bit rise, fall, sel, st, fin;
        hs = {hs[2:0], sclk};
        hc = {hc[2:0], csn};
        hd = {hd[2:0], din};
        if (rst) begin
            sr_q = {};
            for (int i = 0; i < 16; i++) sr_q.push_back(1'b0);
            m_cnt = 0; m_dout = 0; m_strobe = 0; m_valid = 0; m_bits = 0; m_word = '0;
        end else begin
            rise = hs[2] && !hs[3];
            fall = !hs[2] && hs[3];
            sel  = !hc[2];
            st   = !hc[2] && hc[3];
            fin  = hc[2] && !hc[3];
            m_strobe = fin;
            if (fin) begin
                m_word = q_word();
                m_bits = m_cnt;
                m_valid = (m_cnt == 16);
            end
            if (sel && (mode ? rise : fall)) m_dout = sr_q[0];
            if (sel && rise) begin
                void'(sr_q.pop_front());
                sr_q.push_back(hd[2]);
            end
            if (st) m_cnt = 0;
            else if (sel && rise && m_cnt < 17) m_cnt++;
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(mode ? "R5 dout vs model" : "R4 dout vs model", dout, m_dout);
            chk("R3/R9 strobe vs model", strobe, m_strobe);
            chk("R1 word vs model", word, m_word);
            chk("R7 bits vs model", bits, m_bits);
            chk("R7 valid vs model", valid, m_valid);
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n,
                        output logic [31:0] pre_rise, output logic [31:0] pre_fall);
        pre_rise = '0;
        pre_fall = '0;
        for (int i = n - 1; i >= 0; i--) begin
            din = v[i];
            wait_n(H);
            pre_rise[i] = dout;
            sclk = 1'b1;
            wait_n(H);
            pre_fall[i] = dout;
            sclk = 1'b0;
        end
    endtask

    task automatic select();
        csn = 1'b0;
        wait_n(H);
    endtask

    task automatic deselect();
        wait_n(H);
        csn = 1'b1;
        wait_n(6);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pr, pf;
        logic keep;

        wait_n(5);
        // R8: reset state
        chk("R8 dout reset", dout, 0);
        chk("R8 word reset", word, 0);
        chk("R8 bits reset", bits, 0);
        chk("R8 strobe reset", strobe, 0);
        chk("R8 valid reset", valid, 0);
        rst = 1'b0;
        wait_n(5);

        // R1/R3/R9: full frame in falling-edge mode
        mode = 1'b0;
        select();
        send(32'hA5C3, 16, pr, pf);
        wait_n(H);
        csn = 1'b1;                       // R9: strobe appears at the third edge
        wait_n(1); chk("R9 strobe after 1 edge", strobe, 0);
        wait_n(1); chk("R9 strobe after 2 edges", strobe, 0);
        wait_n(1); chk("R9 strobe after 3 edges", strobe, 1);
        wait_n(1); chk("R3 strobe one cycle", strobe, 0);
        chk("R1 word msb first", word, 16'hA5C3);
        chk("R7 bits full", bits, 16);
        chk("R7 valid full", valid, 1);
        wait_n(4);

        // R4: readback of the previous word while shifting in a new one
        select();
        send(32'h3C96, 16, pr, pf);
        deselect();
        chk("R4 readback fall mode", pr[15:0], 16'hA5C3);
        chk("R1 second word", word, 16'h3C96);

        // R6: two bursts of eight with a pause
        select();
        send(32'h5A, 8, pr, pf);
        wait_n(20);
        send(32'h81, 8, pr, pf);
        deselect();
        chk("R6 split word", word, 16'h5A81);
        chk("R6 split valid", valid, 1);

        // R7: short frame
        select();
        send(32'hABC, 12, pr, pf);
        deselect();
        chk("R7 short bits", bits, 12);
        chk("R7 short valid", valid, 0);
        chk("R7 short word", word, 16'h1ABC);

        // R7: long frame, count saturates
        select();
        send(32'hF0F0F, 20, pr, pf);
        deselect();
        chk("R7 long bits saturate", bits, 17);
        chk("R7 long valid", valid, 0);
        chk("R7 long word", word, 16'h0F0F);

        // R2/R10: activity while deselected is ignored
        keep = dout;
        send(32'h00FF, 8, pr, pf);
        wait_n(8);
        chk("R10 dout held idle", dout, keep);
        chk("R2 no frame when idle", word, 16'h0F0F);

        // R5/R2: rising-edge mode reads back the unchanged register
        mode = 1'b1;
        wait_n(4);
        select();
        send(32'h1234, 16, pr, pf);
        deselect();
        chk("R5 readback rise mode", pf[15:0], 16'h0F0F);
        chk("R1 word in rise mode", word, 16'h1234);
        chk("R3 valid rise mode", valid, 1);

        wait_n(10);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule